// File: doc/BRIEF.md
# Banked General-Purpose I/O Port

This block is a general-purpose I/O port of up to 50 pins. Software reaches it through 16-bit registers on a simple synchronous register bus made of an address, a write strobe, write data and a combinational read-data return. It holds a direction bit and an output data bit for each pin. It drives the pin output values and output enables, and it samples the pin inputs through a two-flop synchronizer so they can be read back.

The pin count is fixed at build time. The supported counts are 36, 48 and 50. Pins 0 to 31 sit in two banks, and each bank has its own direction register and data register. Pins 32 to 47 form the upper group. That group has a single register, and each bit in it acts as both the data bit and the drive enable: a set bit drives the pin high, and a clear bit releases the pin. In the 50-pin build, pins 48 and 49 form a tail group. The tail register holds their data bits in its low bits and their output enables in bits 8 and up.

Top module: `gpio_port`

## Requirements
- R1: After reset, every pin_oe and pin_out bit is 0, and the direction registers at offsets 0x00 and 0x02 read 0.
- R2: A write to offset 0x00 sets pin_oe for pins 0–15 from the write data bits 15:0, one bit per pin. A write to offset 0x02 does the same for pins 16–31. A 1 makes the pin an output and a 0 makes it an input. The new enable is visible after the clock edge that takes the write, and pin_oe changes on no other cycle.
- R3: A write to offset 0x04 latches pin_out for pins 0–15, and a write to offset 0x06 latches pin_out for pins 16–31. The latch happens whether the pin is an output or an input.
- R4: Reading offset 0x04 or 0x06 returns, for each bit, the latched output value if the pin is an output and the synchronized pin level if it is an input.
- R5: An input pin change becomes visible in a read after exactly two rising clock edges, and not after one.
- R6: At offset 0x1C, bit i controls pin 32+i. A set bit drives pin_out and pin_oe high. A clear bit releases the pin. A read returns the set bits ORed with the synchronized pin levels.
- R7: In the 50-pin build, offset 0x1E bits 1:0 hold the data for pins 48–49 and bits 9:8 hold their output enables. A read returns bits 9:8 as written, and returns bits 1:0 as the data for enabled pins and as the synchronized level for released pins.
- R8: Register bits that map to pins at or above the pin count hold nothing. Writing them has no effect on any output, and they read 0.
- R9: A read of an odd offset or of any offset other than 0x00, 0x02, 0x04, 0x06, 0x1C and 0x1E (0x1E only in the 50-pin build) returns 0. A write there changes no output and no register.
- R10: The direction registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| pin_in | input | PIN_COUNT | Pin levels from the pads, asynchronous |
| pin_out | output | PIN_COUNT | Output value driven to each pad |
| pin_oe | output | PIN_COUNT | Output enable for each pad, 1 = drive |

## Verification
The direction banks get a walking one across every bit, and each step is checked at pin_oe and at readback. A wrong bit mapping or a bank swap therefore shows up on exactly one pin. The data banks get complementary patterns with every pin an output, and then hashed pin levels under shifting mixed direction masks. This separates the latched-value path from the synchronized-input path bit by bit. The upper and tail groups are driven against all-low and all-high pin levels, which separates the drive bit from the sampled level in the read. Writes of all-ones to unmapped offsets and to the unused tail bits, made from a non-zero state, catch any decode that leaks into real state.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, register offsets and the offset decoder of the GPIO port.
// Assumes byte offsets on a 16-bit register bus; odd offsets are never mapped.
package gpio_port_pkg;

    localparam int REG_W     = 16;
    localparam int ADDR_W    = 5;
    localparam int GROUP_CNT = 4;
    localparam int PAD_W     = GROUP_CNT * REG_W;

    localparam logic [ADDR_W-1:0] OFS_DIR_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_HI = 5'h02;
    localparam logic [ADDR_W-1:0] OFS_DAT_LO = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DAT_HI = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_UPPER  = 5'h1C;
    localparam logic [ADDR_W-1:0] OFS_TAIL   = 5'h1E;

    // Bit of the tail register that holds the enable of tail pin 0.
    localparam int TAIL_OE_BIT = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_LO,
        SEL_DIR_HI,
        SEL_DAT_LO,
        SEL_DAT_HI,
        SEL_UPPER,
        SEL_TAIL
    } reg_sel_e;

    // Map an offset to a register, honouring which groups exist in this build.
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a,
                                            input bit has_upper,
                                            input bit has_tail);
        reg_sel_e s;
        s = SEL_NONE;
        case (a)
            OFS_DIR_LO: s = SEL_DIR_LO;
            OFS_DIR_HI: s = SEL_DIR_HI;
            OFS_DAT_LO: s = SEL_DAT_LO;
            OFS_DAT_HI: s = SEL_DAT_HI;
            OFS_UPPER:  s = has_upper ? SEL_UPPER : SEL_NONE;
            OFS_TAIL:   s = has_tail  ? SEL_TAIL  : SEL_NONE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Module: two-flop synchronizer for a vector of asynchronous pin levels.
// Assumes each bit is independent; no bus coherence is given across bits.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pin levels through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
// Module: one 16-pin bank with a direction register and a data register.
// Assumes PINS <= WIDTH; bits at or above PINS store nothing and read 0.
module gpio_bank #(
    parameter int PINS  = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_we,
    input  logic             dat_we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dir_rd,
    output logic [WIDTH-1:0] dat_rd
);

    localparam logic [WIDTH-1:0] VALID = WIDTH'((65'd1 << PINS) - 65'd1);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] dat_q;

    // Hold the per-pin direction, writing only bits of existing pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (dir_we) begin
            dir_q <= wdata & VALID;
        end
    end

    // Latch the per-pin output value whatever the pin direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
        end else if (dat_we) begin
            dat_q <= wdata & VALID;
        end
    end

    assign oe     = dir_q;
    assign dout   = dat_q;
    assign dir_rd = dir_q;

    // Pick the latched value for outputs and the pin level for inputs.
    always_comb begin
        dat_rd = ((dat_q & dir_q) | (sync_in & ~dir_q)) & VALID;
    end

endmodule

// File: rtl/gpio_upper.sv
`timescale 1ns/1ps
// Module: upper pin group where each register bit is both drive value and enable.
// Assumes PINS <= WIDTH; a set bit drives the pin high, a clear bit releases it.
module gpio_upper #(
    parameter int PINS  = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] drive,
    output logic [WIDTH-1:0] rd
);

    localparam logic [WIDTH-1:0] VALID = WIDTH'((65'd1 << PINS) - 65'd1);

    logic [WIDTH-1:0] drv_q;

    // Store the drive bits of existing pins on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (we) begin
            drv_q <= wdata & VALID;
        end
    end

    assign drive = drv_q;

    // A driven pin reads 1; a released pin reads its sampled level.
    always_comb begin
        rd = (drv_q | sync_in) & VALID;
    end

endmodule

// File: rtl/gpio_tail.sv
`timescale 1ns/1ps
// Module: tail pin group whose data and enables share one register.
// Assumes PINS <= OE_BIT and OE_BIT + PINS <= WIDTH; data in low bits, enables from OE_BIT.
module gpio_tail #(
    parameter int PINS   = 2,
    parameter int OE_BIT = 8,
    parameter int WIDTH  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] sync_in,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] rd
);

    localparam logic [WIDTH-1:0] VALID = WIDTH'((65'd1 << PINS) - 65'd1);

    logic [WIDTH-1:0] dat_q;
    logic [WIDTH-1:0] en_q;

    // Split a write into data bits and enable bits of existing pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_q <= '0;
            en_q  <= '0;
        end else if (we) begin
            dat_q <= wdata & VALID;
            en_q  <= (wdata >> OE_BIT) & VALID;
        end
    end

    assign oe   = en_q;
    assign dout = dat_q;

    // Rebuild the register image: enables as stored, data or pin level below.
    always_comb begin
        rd = (en_q << OE_BIT) | (((dat_q & en_q) | (sync_in & ~en_q)) & VALID);
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
// Module: top of the banked GPIO port; decodes the register bus and maps groups to pins.
// Assumes 32 < PIN_COUNT <= 56 (built as 36, 48 or 50) and reg_addr stable around the edge.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);

    localparam int  LOW_BANKS  = 2;
    localparam int  UPPER_BASE = LOW_BANKS * REG_W;
    localparam int  TAIL_BASE  = UPPER_BASE + REG_W;
    localparam int  UPPER_PINS = (PIN_COUNT >= TAIL_BASE) ? REG_W :
                                 ((PIN_COUNT > UPPER_BASE) ? PIN_COUNT - UPPER_BASE : 0);
    localparam int  TAIL_PINS  = (PIN_COUNT > TAIL_BASE) ? PIN_COUNT - TAIL_BASE : 0;
    localparam bit  HAS_UPPER  = (UPPER_PINS > 0);
    localparam bit  HAS_TAIL   = (TAIL_PINS > 0);

    logic [PIN_COUNT-1:0] sync_q;
    logic [PAD_W-1:0]     in_pad;
    logic [PAD_W-1:0]     oe_pad;
    logic [PAD_W-1:0]     out_pad;
    logic [REG_W-1:0]     dir_rd [LOW_BANKS];
    logic [REG_W-1:0]     dat_rd [LOW_BANKS];
    logic [REG_W-1:0]     upper_rd;
    logic [REG_W-1:0]     tail_rd;
    reg_sel_e             sel;

    gpio_sync #(
        .WIDTH    (PIN_COUNT)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_q)
    );

    assign in_pad = {{(PAD_W - PIN_COUNT){1'b0}}, sync_q};

    // Decode the offset once for both the write enables and the read mux.
    always_comb begin
        sel = decode_sel(reg_addr, HAS_UPPER, HAS_TAIL);
    end

    for (genvar g = 0; g < LOW_BANKS; g++) begin : g_bank
        localparam int BANK_PINS = ((PIN_COUNT - g * REG_W) >= REG_W) ? REG_W
                                                                      : PIN_COUNT - g * REG_W;
        localparam reg_sel_e DIR_SEL = (g == 0) ? SEL_DIR_LO : SEL_DIR_HI;
        localparam reg_sel_e DAT_SEL = (g == 0) ? SEL_DAT_LO : SEL_DAT_HI;

        gpio_bank #(
            .PINS    (BANK_PINS),
            .WIDTH   (REG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_we  (reg_wr && (sel == DIR_SEL)),
            .dat_we  (reg_wr && (sel == DAT_SEL)),
            .wdata   (reg_wdata),
            .sync_in (in_pad[g*REG_W +: REG_W]),
            .oe      (oe_pad[g*REG_W +: REG_W]),
            .dout    (out_pad[g*REG_W +: REG_W]),
            .dir_rd  (dir_rd[g]),
            .dat_rd  (dat_rd[g])
        );
    end

    if (HAS_UPPER) begin : g_upper
        logic [REG_W-1:0] drive;

        gpio_upper #(
            .PINS    (UPPER_PINS),
            .WIDTH   (REG_W)
        ) u_upper (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (reg_wr && (sel == SEL_UPPER)),
            .wdata   (reg_wdata),
            .sync_in (in_pad[UPPER_BASE +: REG_W]),
            .drive   (drive),
            .rd      (upper_rd)
        );

        assign oe_pad[UPPER_BASE +: REG_W]  = drive;
        assign out_pad[UPPER_BASE +: REG_W] = drive;
    end else begin : g_no_upper
        assign oe_pad[UPPER_BASE +: REG_W]  = '0;
        assign out_pad[UPPER_BASE +: REG_W] = '0;
        assign upper_rd                     = '0;
    end

    if (HAS_TAIL) begin : g_tail
        gpio_tail #(
            .PINS    (TAIL_PINS),
            .OE_BIT  (TAIL_OE_BIT),
            .WIDTH   (REG_W)
        ) u_tail (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (reg_wr && (sel == SEL_TAIL)),
            .wdata   (reg_wdata),
            .sync_in (in_pad[TAIL_BASE +: REG_W]),
            .oe      (oe_pad[TAIL_BASE +: REG_W]),
            .dout    (out_pad[TAIL_BASE +: REG_W]),
            .rd      (tail_rd)
        );
    end else begin : g_no_tail
        assign oe_pad[TAIL_BASE +: REG_W]  = '0;
        assign out_pad[TAIL_BASE +: REG_W] = '0;
        assign tail_rd                     = '0;
    end

    assign pin_oe  = oe_pad[PIN_COUNT-1:0];
    assign pin_out = out_pad[PIN_COUNT-1:0];

    // Return the image of the addressed register, or 0 for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_DIR_LO: reg_rdata = dir_rd[0];
            SEL_DIR_HI: reg_rdata = dir_rd[1];
            SEL_DAT_LO: reg_rdata = dat_rd[0];
            SEL_DAT_HI: reg_rdata = dat_rd[1];
            SEL_UPPER:  reg_rdata = upper_rd;
            SEL_TAIL:   reg_rdata = tail_rd;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for gpio_port, attached by bind below.
// Assumes the same PIN_COUNT as the bound instance.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT = 50
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe
);

    function automatic bit is_mapped(input logic [ADDR_W-1:0] a);
        return (a == 5'h00) || (a == 5'h02) || (a == 5'h04) || (a == 5'h06) ||
               (a == 5'h1C && PIN_COUNT > 32) || (a == 5'h1E && PIN_COUNT > 48);
    endfunction

    // R1: outputs are quiet on the first cycle out of reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

    // R2: low direction write lands on the low sixteen enables.
    p_dir_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h00) |=> (pin_oe[15:0] == $past(reg_wdata)));

    // R2: enables move only after a write.
    p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(pin_oe));

    // R3: high data write lands on pins 16 to 31.
    p_dat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h06) |=> (pin_out[31:16] == $past(reg_wdata)));

    // R9: unmapped reads return zero.
    p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mapped(reg_addr) |-> (reg_rdata == '0));

    // R9: unmapped writes leave every output unchanged.
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !is_mapped(reg_addr)) |=> ($stable(pin_oe) && $stable(pin_out)));

    if (PIN_COUNT >= 48) begin : g_upper_chk
        // R6: upper group write sets drive and enable together.
        p_upper_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 5'h1C) |=>
                (pin_oe[47:32] == $past(reg_wdata) && pin_out[47:32] == $past(reg_wdata)));
    end

    if (PIN_COUNT == 50) begin : g_tail_chk
        // R7: tail enables come from bits 9:8, data from bits 1:0.
        p_tail_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 5'h1E) |=>
                (pin_oe[49:48] == $past(reg_wdata[9:8]) && pin_out[49:48] == $past(reg_wdata[1:0])));
    end

endmodule

bind gpio_port gpio_port_chk #(
    .PIN_COUNT (PIN_COUNT)
) u_gpio_port_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every register of the 50-pin build against an arithmetic model.
module gpio_port_bench;

    localparam int N = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    addr = '0;
    logic          wr = 1'b0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_dir0 = '0, m_dir1 = '0, m_dat0 = '0, m_dat1 = '0, m_up = '0;
    logic [1:0]  m_td = '0, m_te = '0;

    always #10 clk = ~clk;

    gpio_port #(.PIN_COUNT(N)) u_gpio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_wr    (wr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_wr(input logic [4:0] a, input logic [15:0] d);
        case (a)
            5'h00: m_dir0 = d;
            5'h02: m_dir1 = d;
            5'h04: m_dat0 = d;
            5'h06: m_dat1 = d;
            5'h1C: m_up   = d;
            5'h1E: begin m_td = d[1:0]; m_te = d[9:8]; end
            default: ;
        endcase
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #2 v = rdata;
    endtask

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return m_dir0;
            5'h02: return m_dir1;
            5'h04: return (m_dat0 & m_dir0) | (pin_in[15:0] & ~m_dir0);
            5'h06: return (m_dat1 & m_dir1) | (pin_in[31:16] & ~m_dir1);
            5'h1C: return m_up | pin_in[47:32];
            5'h1E: return {6'b0, m_te, 6'b0, (m_td & m_te) | (pin_in[49:48] & ~m_te)};
            default: return 16'h0;
        endcase
    endfunction

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [15:0] v;
        logic [4:0]  regs [6] = '{5'h00, 5'h02, 5'h04, 5'h06, 5'h1C, 5'h1E};
        @(negedge clk);
        #2;
        chk({tag, " pin_oe"},  64'(pin_oe),  64'({m_te, m_up, m_dir1, m_dir0}));
        chk({tag, " pin_out"}, 64'(pin_out), 64'({m_td, m_up, m_dat1, m_dat0}));
        for (int i = 0; i < 6; i++) begin
            rd_reg(regs[i], v);
            chk($sformatf("%s read 0x%02h", tag, regs[i]), 64'(v), 64'(exp_rd(regs[i])));
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] pats [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'h3CF0};
        logic [4:0]  bad  [9] = '{5'h01, 5'h03, 5'h08, 5'h0A, 5'h10, 5'h14, 5'h18, 5'h1A, 5'h1F};

        repeat (4) @(negedge clk);
        #2;
        chk("R1 reset pin_oe", 64'(pin_oe), 64'h0);
        chk("R1 reset pin_out", 64'(pin_out), 64'h0);
        rst_n = 1'b1;
        check_all("R1 after reset");

        // R2 and R10: walking one through both direction registers.
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 16; b++) begin
                wr_reg(g ? 5'h02 : 5'h00, 16'(1) << b);
                #2;
                chk($sformatf("R2 dir bank %0d bit %0d", g, b), 64'(pin_oe), 64'({m_te, m_up, m_dir1, m_dir0}));
                rd_reg(g ? 5'h02 : 5'h00, v);
                chk($sformatf("R10 readback bank %0d bit %0d", g, b), 64'(v), 64'(16'(1) << b));
            end
            wr_reg(g ? 5'h02 : 5'h00, 16'h0);
        end

        // R3: data latched while all pins are still inputs.
        wr_reg(5'h04, 16'h1234);
        wr_reg(5'h06, 16'hFEDC);
        check_all("R3 latch while input");

        // R3 and R4: all outputs, complementary patterns.
        wr_reg(5'h00, 16'hFFFF);
        wr_reg(5'h02, 16'hFFFF);
        for (int p = 0; p < 4; p++) begin
            pin_in = N'(64'h0F0F_5555_AAAA_3333) ^ {N{p[0]}};
            wr_reg(5'h04, pats[p]);
            wr_reg(5'h06, ~pats[p]);
            settle();
            check_all($sformatf("R3 R4 outputs pattern %0d", p));
        end

        // R4: hashed pin levels under shifting mixed directions.
        for (int k = 0; k < 8; k++) begin
            logic [63:0] h;
            h = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
            pin_in = h[N-1:0];
            wr_reg(5'h00, 16'h00FF << k);
            wr_reg(5'h02, 16'hF0F0 >> k);
            wr_reg(5'h04, h[63:48]);
            wr_reg(5'h06, h[55:40]);
            settle();
            check_all($sformatf("R4 mixed %0d", k));
        end

        // R5: two-edge synchronizer latency on an input pin.
        wr_reg(5'h00, 16'h0000);
        pin_in = '0;
        settle();
        @(negedge clk);
        addr = 5'h04; wr = 1'b0; pin_in[5] = 1'b1;
        @(posedge clk); #5;
        chk("R5 one edge", 64'(rdata[5]), 64'h0);
        @(posedge clk); #5;
        chk("R5 two edges", 64'(rdata[5]), 64'h1);

        // R6: walking drive bit in the upper group against low and high pins.
        for (int lvl = 0; lvl < 2; lvl++) begin
            pin_in = lvl ? '1 : '0;
            settle();
            for (int b = 0; b < 16; b++) begin
                wr_reg(5'h1C, 16'(1) << b);
                check_all($sformatf("R6 level %0d bit %0d", lvl, b));
            end
        end
        wr_reg(5'h1C, 16'h0);

        // R7: tail data and enables.
        for (int t = 0; t < 8; t++) begin
            pin_in[49:48] = 2'(t >> 1) ^ 2'b01;
            wr_reg(5'h1E, {6'b0, 2'(t), 6'b0, 2'(t * 3)});
            settle();
            check_all($sformatf("R7 tail %0d", t));
        end

        // R8: bits of absent pins in the tail register.
        wr_reg(5'h1E, 16'h0000);
        wr_reg(5'h1E, 16'hFCFC);
        check_all("R8 absent tail bits");
        rd_reg(5'h1E, v);
        chk("R8 absent bits read zero", 64'(v & 16'hFCFC), 64'h0);

        // R9: unmapped offsets from a non-zero state.
        wr_reg(5'h00, 16'h5A5A);
        wr_reg(5'h04, 16'hC3C3);
        wr_reg(5'h1C, 16'h0F0F);
        wr_reg(5'h1E, 16'h0102);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            addr = bad[i]; wdata = 16'hFFFF; wr = 1'b1;
            @(negedge clk);
            wr = 1'b0;
            rd_reg(bad[i], v);
            chk($sformatf("R9 read 0x%02h", bad[i]), 64'(v), 64'h0);
            check_all($sformatf("R9 after write 0x%02h", bad[i]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule